// File: doc/BRIEF.md
# Microthread Create and Context Scheduler

This block is the local thread scheduler of one core in a many-core array built on fine-grained hardware threads. It keeps a table of thread slots, a pool of free slots, a pool of free register blocks, and a first-in first-out queue of threads that are ready to run. A create request takes the lowest free slot and the lowest free 32-register block. It records the thread's code pointer, its own register base and the base and slot of the context it depends on. It then asks the register file to set up the new context and asks the instruction fetch side to prefetch the first instruction.

A thread becomes runnable only when the fetch side reports that its prefetch has completed. The pipeline asks for the next thread with a switch request. External logic returns suspended threads with a reschedule event and retires threads with a kill event, which returns the slot and the register block to their pools. The pipeline reports each new program counter of a thread. The block stores that value and flags a forced context switch when the new value lies in a different cache line from the stored one.

Top module: `mts_sched`

## Requirements
- R1: `create_ready` is high exactly when at least one slot and at least one register block are free. While it is low, a held `create_valid` is not accepted and produces no `init_valid` pulse.
- R2: An accepted create takes the lowest-numbered free slot and the lowest-numbered free register block. The context base address is the block number times 32.
- R3: One cycle after acceptance, `init_valid` pulses for one cycle. With it, `init_base` gives the new base and `init_index` gives the thread index, which the register file writes into register 0 of the context while it marks the other 31 registers empty.
- R4: In the same cycle as `init_valid`, `pf_valid` pulses with the new slot on `pf_slot` and its code pointer on `pf_pc`.
- R5: A created slot enters the ready queue only when `pf_done_valid` names it. A switch request with an empty queue and no arriving slot gives `issue_valid` low in the next cycle.
- R6: The ready queue is first-in first-out. When a prefetch completion and a reschedule arrive at the same edge, the prefetched slot is queued ahead of the rescheduled one.
- R7: If the queue is empty and a slot arrives at the same edge as a switch request, that slot is issued straight away.
- R8: One cycle after a switch request that finds a slot, `issue_valid` pulses. With it, `issue_slot`, `issue_pc`, `issue_base`, `issue_dep_base` and `issue_dep_slot` give that slot's stored values.
- R9: A kill returns the slot and its register block to their pools at that edge. A create can use them from the next cycle.
- R10: `step_valid` writes `step_pc` into the named slot's stored program counter. `force_switch` is high in the same cycle when the bits of `step_pc` above the low `LINE_OFF_W` bits differ from those of the stored value.
- R11: At a single edge the block accepts one create, one reschedule and one switch request, and acts on all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| create_valid | input | 1 | Create request |
| create_pc | input | PC_W | Code pointer of the new thread |
| create_index | input | IDX_W | Index value of the new thread |
| create_dep_base | input | RA_W | Register base of the context depended on |
| create_dep_slot | input | SLOT_W | Slot of the context depended on |
| create_ready | output | 1 | A slot and a register block are free |
| init_valid | output | 1 | Context set-up pulse |
| init_base | output | RA_W | Base address of the new context |
| init_index | output | IDX_W | Value for register 0 of the new context |
| pf_valid | output | 1 | Prefetch request pulse |
| pf_slot | output | SLOT_W | Slot being prefetched |
| pf_pc | output | PC_W | Address to prefetch |
| pf_done_valid | input | 1 | Prefetch completed |
| pf_done_slot | input | SLOT_W | Slot whose prefetch completed |
| resched_valid | input | 1 | Suspended thread becomes ready |
| resched_slot | input | SLOT_W | Slot made ready |
| switch_req | input | 1 | Pipeline asks for the next thread |
| issue_valid | output | 1 | A thread was handed to the pipeline |
| issue_slot | output | SLOT_W | Issued slot |
| issue_pc | output | PC_W | Stored program counter of the issued slot |
| issue_base | output | RA_W | Register base of the issued slot |
| issue_dep_base | output | RA_W | Dependency base of the issued slot |
| issue_dep_slot | output | SLOT_W | Dependency slot of the issued slot |
| kill_valid | input | 1 | Thread terminates |
| kill_slot | input | SLOT_W | Slot to release |
| step_valid | input | 1 | New program counter report |
| step_slot | input | SLOT_W | Slot the report belongs to |
| step_pc | input | PC_W | New program counter |
| force_switch | output | 1 | New program counter leaves the stored cache line |

## Verification
Every registered result shows up in the cycle after the edge at which its cause is sampled. This covers the set-up and prefetch pulses after an accepted create, the issue record after a switch request, and the rise of `create_ready` after a kill. The bench therefore drives stimulus 1 ns after a rising edge and checks these outputs 1 ns after the following edge. `force_switch` is the one combinational result, and it is checked 1 ns after its inputs are applied, before the edge that stores the new program counter. Queue order and pass-through are checked by issuing slots in consecutive cycles and comparing each slot with the order in which it was made ready.

// File: rtl/mts_pkg.sv
package mts_pkg;
    localparam int CTX_REGS  = 32;
    localparam int CTX_SHIFT = $clog2(CTX_REGS);
endpackage

// File: rtl/mts_bitalloc.sv
module mts_bitalloc #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         rel_valid,
    input  logic [W-1:0] rel_idx,
    output logic         any_free,
    output logic [W-1:0] free_idx
);
    typedef struct packed {
        logic [N-1:0] free;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        any_free = |st_q.free;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (st_q.free[i]) free_idx = W'(i);
        end
        st_d = st_q;
        if (take && any_free) st_d.free[free_idx] = 1'b0;
        if (rel_valid) st_d.free[rel_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{free: '1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mts_actq.sv
module mts_actq #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push0_valid,
    input  logic [W-1:0] push0_slot,
    input  logic         push1_valid,
    input  logic [W-1:0] push1_slot,
    input  logic         pop,
    output logic         q_avail,
    output logic [W-1:0] q_slot
);
    typedef struct packed {
        logic [N-1:0][W-1:0] mem;
        logic [W-1:0]        rd;
        logic [W-1:0]        wr;
        logic [W:0]          cnt;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [W-1:0] nxt(input logic [W-1:0] p);
        return (p == W'(N - 1)) ? '0 : p + 1'b1;
    endfunction

    logic         empty, take, bypass, w0, w1;
    logic [W-1:0] wp;

    always_comb begin
        empty   = (st_q.cnt == '0);
        q_avail = !empty || push0_valid || push1_valid;
        take    = pop && q_avail;
        bypass  = take && empty;
        q_slot  = !empty ? st_q.mem[st_q.rd]
                         : (push0_valid ? push0_slot : push1_slot);
        w0 = push0_valid && !bypass;
        w1 = push1_valid && !(bypass && !push0_valid);

        st_d = st_q;
        wp   = st_q.wr;
        if (w0) begin
            st_d.mem[wp] = push0_slot;
            wp = nxt(wp);
        end
        if (w1) begin
            st_d.mem[wp] = push1_slot;
            wp = nxt(wp);
        end
        st_d.wr = wp;
        if (take && !empty) st_d.rd = nxt(st_q.rd);
        st_d.cnt = st_q.cnt + (W+1)'(w0) + (W+1)'(w1) - (W+1)'(take && !empty);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mts_sched.sv
module mts_sched
    import mts_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int NUM_BLOCKS = 6,
    parameter int PC_W       = 16,
    parameter int IDX_W      = 16,
    parameter int LINE_OFF_W = 4,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int RA_W   = BLK_W + CTX_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              create_valid,
    input  logic [PC_W-1:0]   create_pc,
    input  logic [IDX_W-1:0]  create_index,
    input  logic [RA_W-1:0]   create_dep_base,
    input  logic [SLOT_W-1:0] create_dep_slot,
    output logic              create_ready,
    output logic              init_valid,
    output logic [RA_W-1:0]   init_base,
    output logic [IDX_W-1:0]  init_index,
    output logic              pf_valid,
    output logic [SLOT_W-1:0] pf_slot,
    output logic [PC_W-1:0]   pf_pc,
    input  logic              pf_done_valid,
    input  logic [SLOT_W-1:0] pf_done_slot,
    input  logic              resched_valid,
    input  logic [SLOT_W-1:0] resched_slot,
    input  logic              switch_req,
    output logic              issue_valid,
    output logic [SLOT_W-1:0] issue_slot,
    output logic [PC_W-1:0]   issue_pc,
    output logic [RA_W-1:0]   issue_base,
    output logic [RA_W-1:0]   issue_dep_base,
    output logic [SLOT_W-1:0] issue_dep_slot,
    input  logic              kill_valid,
    input  logic [SLOT_W-1:0] kill_slot,
    input  logic              step_valid,
    input  logic [SLOT_W-1:0] step_slot,
    input  logic [PC_W-1:0]   step_pc,
    output logic              force_switch
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][PC_W-1:0]   pc;
        logic [NUM_SLOTS-1:0][BLK_W-1:0]  blk;
        logic [NUM_SLOTS-1:0][RA_W-1:0]   dep_base;
        logic [NUM_SLOTS-1:0][SLOT_W-1:0] dep_slot;
        logic              init_valid;
        logic [RA_W-1:0]   init_base;
        logic [IDX_W-1:0]  init_index;
        logic              pf_valid;
        logic [SLOT_W-1:0] pf_slot;
        logic [PC_W-1:0]   pf_pc;
        logic              issue_valid;
        logic [SLOT_W-1:0] issue_slot;
        logic [PC_W-1:0]   issue_pc;
        logic [RA_W-1:0]   issue_base;
        logic [RA_W-1:0]   issue_dep_base;
        logic [SLOT_W-1:0] issue_dep_slot;
    } st_t;

    st_t st_d, st_q;

    logic              slot_any, blk_any, create_fire, q_avail;
    logic [SLOT_W-1:0] slot_idx, q_slot;
    logic [BLK_W-1:0]  blk_idx;

    assign create_ready = slot_any && blk_any;
    assign create_fire  = create_valid && create_ready;

    mts_bitalloc #(.N(NUM_SLOTS)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (create_fire),
        .rel_valid(kill_valid),
        .rel_idx  (kill_slot),
        .any_free (slot_any),
        .free_idx (slot_idx)
    );

    mts_bitalloc #(.N(NUM_BLOCKS)) u_blocks (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (create_fire),
        .rel_valid(kill_valid),
        .rel_idx  (st_q.blk[kill_slot]),
        .any_free (blk_any),
        .free_idx (blk_idx)
    );

    mts_actq #(.N(NUM_SLOTS)) u_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .push0_valid(pf_done_valid),
        .push0_slot (pf_done_slot),
        .push1_valid(resched_valid),
        .push1_slot (resched_slot),
        .pop        (switch_req),
        .q_avail    (q_avail),
        .q_slot     (q_slot)
    );

    always_comb begin
        st_d = st_q;
        st_d.init_valid  = 1'b0;
        st_d.pf_valid    = 1'b0;
        st_d.issue_valid = 1'b0;

        force_switch = step_valid &&
            (step_pc[PC_W-1:LINE_OFF_W] != st_q.pc[step_slot][PC_W-1:LINE_OFF_W]);

        if (step_valid) st_d.pc[step_slot] = step_pc;

        if (create_fire) begin
            st_d.pc[slot_idx]       = create_pc;
            st_d.blk[slot_idx]      = blk_idx;
            st_d.dep_base[slot_idx] = create_dep_base;
            st_d.dep_slot[slot_idx] = create_dep_slot;
            st_d.init_valid         = 1'b1;
            st_d.init_base          = {blk_idx, {CTX_SHIFT{1'b0}}};
            st_d.init_index         = create_index;
            st_d.pf_valid           = 1'b1;
            st_d.pf_slot            = slot_idx;
            st_d.pf_pc              = create_pc;
        end

        if (switch_req && q_avail) begin
            st_d.issue_valid    = 1'b1;
            st_d.issue_slot     = q_slot;
            st_d.issue_pc       = (step_valid && step_slot == q_slot) ? step_pc
                                                                      : st_q.pc[q_slot];
            st_d.issue_base     = {st_q.blk[q_slot], {CTX_SHIFT{1'b0}}};
            st_d.issue_dep_base = st_q.dep_base[q_slot];
            st_d.issue_dep_slot = st_q.dep_slot[q_slot];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign init_valid     = st_q.init_valid;
    assign init_base      = st_q.init_base;
    assign init_index     = st_q.init_index;
    assign pf_valid       = st_q.pf_valid;
    assign pf_slot        = st_q.pf_slot;
    assign pf_pc          = st_q.pf_pc;
    assign issue_valid    = st_q.issue_valid;
    assign issue_slot     = st_q.issue_slot;
    assign issue_pc       = st_q.issue_pc;
    assign issue_base     = st_q.issue_base;
    assign issue_dep_base = st_q.issue_dep_base;
    assign issue_dep_slot = st_q.issue_dep_slot;
endmodule

// File: rtl/mts_sched_chk.sv
module mts_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic create_valid,
    input logic create_ready,
    input logic init_valid,
    input logic switch_req,
    input logic issue_valid,
    input logic kill_valid,
    input logic step_valid,
    input logic force_switch
);
    a_r3_init_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (create_valid && create_ready) |=> init_valid);

    a_r1_no_init_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !(create_valid && create_ready) |=> !init_valid);

    a_r8_issue_needs_switch: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> $past(switch_req));

    a_r9_ready_after_kill: assert property (@(posedge clk) disable iff (!rst_n)
        kill_valid |=> create_ready);

    a_r10_force_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        force_switch |-> step_valid);
endmodule

bind mts_sched mts_sched_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .create_valid (create_valid),
    .create_ready (create_ready),
    .init_valid   (init_valid),
    .switch_req   (switch_req),
    .issue_valid  (issue_valid),
    .kill_valid   (kill_valid),
    .step_valid   (step_valid),
    .force_switch (force_switch)
);

// File: tb/tb_mts_sched.sv
module tb_mts_sched;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        create_valid;
    logic [15:0] create_pc;
    logic [15:0] create_index;
    logic [7:0]  create_dep_base;
    logic [2:0]  create_dep_slot;
    logic        create_ready;
    logic        init_valid;
    logic [7:0]  init_base;
    logic [15:0] init_index;
    logic        pf_valid;
    logic [2:0]  pf_slot;
    logic [15:0] pf_pc;
    logic        pf_done_valid;
    logic [2:0]  pf_done_slot;
    logic        resched_valid;
    logic [2:0]  resched_slot;
    logic        switch_req;
    logic        issue_valid;
    logic [2:0]  issue_slot;
    logic [15:0] issue_pc;
    logic [7:0]  issue_base;
    logic [7:0]  issue_dep_base;
    logic [2:0]  issue_dep_slot;
    logic        kill_valid;
    logic [2:0]  kill_slot;
    logic        step_valid;
    logic [2:0]  step_slot;
    logic [15:0] step_pc;
    logic        force_switch;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mts_sched dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        create_valid = 0; pf_done_valid = 0; resched_valid = 0;
        switch_req = 0; kill_valid = 0; step_valid = 0;
    endtask

    task automatic set_create(input logic [15:0] pc, input logic [15:0] idx,
                              input logic [7:0] db, input logic [2:0] ds);
        create_valid = 1; create_pc = pc; create_index = idx;
        create_dep_base = db; create_dep_slot = ds;
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", create_ready, 1);
        chk("R3 init idle after reset", init_valid, 0);
        chk("R4 prefetch idle after reset", pf_valid, 0);
        chk("R8 issue idle after reset", issue_valid, 0);
        chk("R10 force idle after reset", force_switch, 0);
    endtask

    task automatic t_first_create();
        set_create(16'h0100, 16'd7, 8'h20, 3'd3);
        cyc(); idle();
        chk("R3 init pulse", init_valid, 1);
        chk("R2 first base", init_base, 0);
        chk("R3 index", init_index, 7);
        chk("R4 prefetch pulse", pf_valid, 1);
        chk("R2 first slot", pf_slot, 0);
        chk("R4 prefetch pc", pf_pc, 16'h0100);
        cyc();
        chk("R3 init one cycle", init_valid, 0);
    endtask

    task automatic t_wait_prefetch();
        switch_req = 1;
        cyc();
        chk("R5 not ready before prefetch", issue_valid, 0);
        pf_done_valid = 1; pf_done_slot = 0;
        cyc(); idle();
        chk("R7 pass-through", issue_valid, 1);
        chk("R8 slot", issue_slot, 0);
        chk("R8 pc", issue_pc, 16'h0100);
        chk("R8 base", issue_base, 0);
        chk("R8 dep base", issue_dep_base, 8'h20);
        chk("R8 dep slot", issue_dep_slot, 3);
        cyc();
        chk("R8 issue one cycle", issue_valid, 0);
    endtask

    task automatic t_order();
        set_create(16'h0200, 16'd1, 8'h00, 3'd0);
        cyc();
        chk("R2 second base", init_base, 32);
        set_create(16'h0300, 16'd2, 8'h00, 3'd0);
        cyc(); idle();
        chk("R2 third base", init_base, 64);
        chk("R2 third slot", pf_slot, 2);
        pf_done_valid = 1; pf_done_slot = 2;
        cyc();
        pf_done_slot = 1;
        cyc(); idle();
        switch_req = 1;
        cyc();
        chk("R6 first in first out", issue_slot, 2);
        chk("R8 pc of slot 2", issue_pc, 16'h0300);
        cyc(); idle();
        chk("R6 second out", issue_slot, 1);
        chk("R8 base of slot 1", issue_base, 32);
        pf_done_valid = 1; pf_done_slot = 0;
        resched_valid = 1; resched_slot = 1;
        cyc(); idle();
        switch_req = 1;
        cyc();
        chk("R6 prefetch ahead of reschedule", issue_slot, 0);
        cyc(); idle();
        chk("R6 reschedule after prefetch", issue_slot, 1);
    endtask

    task automatic t_same_cycle();
        resched_valid = 1; resched_slot = 2;
        cyc(); idle();
        set_create(16'h0400, 16'd4, 8'h00, 3'd0);
        resched_valid = 1; resched_slot = 0;
        switch_req = 1;
        cyc(); idle();
        chk("R11 switch served", issue_slot, 2);
        chk("R11 switch valid", issue_valid, 1);
        chk("R11 create served", pf_slot, 3);
        chk("R11 create base", init_base, 96);
        switch_req = 1;
        cyc(); idle();
        chk("R11 reschedule served", issue_slot, 0);
        cyc();
        chk("R5 queue drained", issue_valid, 0);
    endtask

    task automatic t_exhaust_kill();
        set_create(16'h0500, 16'd5, 8'h00, 3'd0);
        cyc();
        set_create(16'h0600, 16'd6, 8'h00, 3'd0);
        cyc(); idle();
        chk("R1 no block free", create_ready, 0);
        set_create(16'h0700, 16'd8, 8'h00, 3'd0);
        cyc();
        chk("R1 create waits", init_valid, 0);
        kill_valid = 1; kill_slot = 1;
        cyc(); kill_valid = 0;
        chk("R9 ready after kill", create_ready, 1);
        chk("R1 still waiting", init_valid, 0);
        cyc(); idle();
        chk("R9 reuse slot", pf_slot, 1);
        chk("R9 reuse block", init_base, 32);
        chk("R9 waited pc", pf_pc, 16'h0700);
        kill_valid = 1; kill_slot = 4;
        cyc();
        kill_slot = 2;
        cyc(); idle();
        set_create(16'h0800, 16'd9, 8'h00, 3'd0);
        cyc(); idle();
        chk("R2 lowest free slot", pf_slot, 2);
        chk("R2 lowest free block", init_base, 64);
    endtask

    task automatic t_step();
        step_valid = 1; step_slot = 0; step_pc = 16'h0104;
        #1;
        chk("R10 same line", force_switch, 0);
        cyc();
        step_pc = 16'h0110;
        #1;
        chk("R10 line crossed", force_switch, 1);
        cyc(); idle();
        #1;
        chk("R10 no step no force", force_switch, 0);
        resched_valid = 1; resched_slot = 0; switch_req = 1;
        cyc(); idle();
        chk("R10 stored pc", issue_pc, 16'h0110);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        idle();
        create_pc = 0; create_index = 0; create_dep_base = 0; create_dep_slot = 0;
        pf_done_slot = 0; resched_slot = 0; kill_slot = 0; step_slot = 0; step_pc = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        t_reset();
        t_first_create();
        t_wait_prefetch();
        t_order();
        t_same_cycle();
        t_exhaust_kill();
        t_step();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule